// File: doc/BRIEF.md
# Factory Bad-Block Table Scanner

This block runs once after power-up, before any erase command can reach a small-page NAND flash. It walks every erase block from address zero upward. For each block it reads one byte from the spare area of page 0 and then of page 1. Erased cells read FFh, and the manufacturer marks a defective block with any other value at spare column 5, which is overall column 517. Because an erase would wipe that mark, the scan has to finish before any erase.

Every page read has the same form. The block sends the spare-area pointer command (50h), then three address cycles: the spare column, the low row byte and the high row byte. It waits out the write-to-busy window, waits until the device's ready/busy line reports ready again, and then pulses the read strobe once. After both pages of a block have been read, the block writes one flag into an external bitmap memory and counts the block if it is good. When the last block has been written it raises `done` and reports the good-block total. It also raises a low-capacity flag if that total is below the guaranteed minimum.

Top module: `bbt_scanner`

## Requirements
- R1: While reset is held and directly after it: nd_ce_n, nd_we_n and nd_re_n are 1; nd_cle, nd_ale, nd_io_oe, bm_we, done and low_cap are 0; good_count is 0.
- R2: Each page read writes command byte 50h (with nd_cle high), then three address bytes with nd_ale high, in this order: 05h, row[7:0], {2'b00, row[13:8]}. Here row = block*16 + page. Each byte is taken on a rising edge of nd_we_n.
- R3: After the last address byte, nd_re_n is never lowered while nd_rb is low. The block first waits WB_CYC cycles, then waits for nd_rb to be seen high.
- R4: Both page 0 and page 1 of every block are read, so a scan makes exactly 2*NUM_BLOCKS read strobes. A block is bad (bm_bad=1) if either byte read differs from FFh.
- R5: Blocks are visited in ascending order from 0 to NUM_BLOCKS-1, and block 0 is included. Each block gets exactly one bitmap write (bm_we high for one cycle) with bm_addr equal to the block number.
- R6: At done, good_count equals the number of blocks written with bm_bad=0. A start that is accepted clears good_count to 0.
- R7: While done is high, low_cap is 1 exactly when good_count < MIN_GOOD (default 1014). At exactly MIN_GOOD it is 0.
- R8: The only command byte ever written is 50h. No erase, program or other command is issued.
- R9: done rises after the last bitmap write and stays high until start is asserted again, which begins a new scan.
- R10: nd_cle and nd_ale are never high together, and nd_ce_n is 0 whenever nd_we_n or nd_re_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a scan; accepted while idle or done |
| done | output | 1 | Scan complete; held until the next start |
| nd_ce_n | output | 1 | Flash chip select, active low |
| nd_cle | output | 1 | Command latch strobe qualifier |
| nd_ale | output | 1 | Address latch strobe qualifier |
| nd_we_n | output | 1 | Write strobe; the flash latches on its rising edge |
| nd_re_n | output | 1 | Read strobe, active low |
| nd_io_out | output | 8 | Byte driven onto the flash bus |
| nd_io_oe | output | 1 | Output enable for nd_io_out |
| nd_io_in | input | 8 | Byte returned by the flash |
| nd_rb | input | 1 | Ready (1) / busy (0) from the flash, asynchronous |
| bm_we | output | 1 | Bitmap write strobe, one cycle per block |
| bm_addr | output | BLK_W | Block number being written |
| bm_bad | output | 1 | 1 if the block carries a factory mark |
| good_count | output | CNT_W | Number of good blocks found so far |
| low_cap | output | 1 | Good-block total is below MIN_GOOD at done |

## Verification
A block's bitmap write and the good-count update fall in the same cycle. In the cycle after the final block's write, `done` rises while the count takes its last increment, and the low-capacity comparison must use that final value. The stimulus vectors place bad blocks at block 0, at the last block and at the exact MIN_GOOD boundary. Each vector also sets marker values next to FFh, and one vector marks both pages of the same block. The bench then compares the count, the flag and every bitmap entry against totals it computes on its own. A flash model holds R/B low for many cycles after each address. Any read strobe that arrives during that window is counted as a violation.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

  typedef enum logic [1:0] {
    BUS_CMD  = 2'd0,
    BUS_ADDR = 2'd1,
    BUS_READ = 2'd2
  } bus_kind_t;

  typedef enum logic [3:0] {
    S_IDLE  = 4'd0,
    S_CMD   = 4'd1,
    S_A0    = 4'd2,
    S_A1    = 4'd3,
    S_A2    = 4'd4,
    S_WB    = 4'd5,
    S_RB    = 4'd6,
    S_READ  = 4'd7,
    S_WRITE = 4'd8,
    S_DONE  = 4'd9
  } scan_st_t;

  localparam logic [7:0] CMD_SPARE_PTR = 8'h50;
  localparam logic [7:0] ERASED_BYTE   = 8'hFF;
  localparam logic [7:0] MARK_COLUMN   = 8'h05;
  localparam int         PAGE_SHIFT    = 4;

  // Row address of a page: block number times pages-per-block, plus the page.
  function automatic logic [13:0] row_of(input logic [13:0] blk, input logic pg);
    return (blk << PAGE_SHIFT) | {13'd0, pg};
  endfunction

  // Byte sent in address cycle idx (0..2) for a given row.
  function automatic logic [7:0] addr_byte(input logic [1:0] idx, input logic [13:0] row);
    case (idx)
      2'd0:    return MARK_COLUMN;
      2'd1:    return row[7:0];
      default: return {2'b00, row[13:8]};
    endcase
  endfunction

  function automatic logic is_marked(input logic [7:0] b);
    return b != ERASED_BYTE;
  endfunction

endpackage

// File: rtl/bbs_sync.sv
module bbs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/bbs_bus_cycler.sv
module bbs_bus_cycler
  import bbs_pkg::*;
#(
  parameter int PULSE_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  bus_kind_t  kind,
  input  logic [7:0] wbyte,
  output logic       ack,
  output logic [7:0] rbyte,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] io_out,
  output logic       io_oe,
  input  logic [7:0] io_in
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

  typedef enum logic [1:0] {C_IDLE, C_SET, C_LOW, C_HIGH} cyc_st_t;

  cyc_st_t   st;
  logic [CW-1:0] cnt;
  logic      is_read;

  assign ack = (st == C_HIGH) && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= C_IDLE;
      cnt     <= '0;
      is_read <= 1'b0;
      cle     <= 1'b0;
      ale     <= 1'b0;
      we_n    <= 1'b1;
      re_n    <= 1'b1;
      io_out  <= 8'h00;
      io_oe   <= 1'b0;
      rbyte   <= 8'h00;
    end else begin
      case (st)
        C_IDLE: if (req) begin
          is_read <= (kind == BUS_READ);
          cle     <= (kind == BUS_CMD);
          ale     <= (kind == BUS_ADDR);
          io_out  <= wbyte;
          io_oe   <= (kind != BUS_READ);
          cnt     <= '0;
          st      <= C_SET;
        end
        C_SET: begin
          if (is_read) re_n <= 1'b0;
          else         we_n <= 1'b0;
          cnt <= '0;
          st  <= C_LOW;
        end
        C_LOW: begin
          if (cnt == LAST) begin
            we_n <= 1'b1;
            re_n <= 1'b1;
            if (is_read) rbyte <= io_in;
            cnt <= '0;
            st  <= C_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == LAST) begin
            cle   <= 1'b0;
            ale   <= 1'b0;
            io_oe <= 1'b0;
            st    <= C_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bbs_tally.sv
module bbs_tally #(
  parameter int CNT_W    = 11,
  parameter int MIN_GOOD = 1014
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             closed,
  output logic [CNT_W-1:0] count,
  output logic             low
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  assign low = closed && (count < CNT_W'(MIN_GOOD));
endmodule

// File: rtl/bbt_scanner.sv
module bbt_scanner
  import bbs_pkg::*;
#(
  parameter int NUM_BLOCKS = 1024,
  parameter int MIN_GOOD   = 1014,
  parameter int PULSE_CYC  = 3,
  parameter int WB_CYC     = 4,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             done,
  output logic             nd_ce_n,
  output logic             nd_cle,
  output logic             nd_ale,
  output logic             nd_we_n,
  output logic             nd_re_n,
  output logic [7:0]       nd_io_out,
  output logic             nd_io_oe,
  input  logic [7:0]       nd_io_in,
  input  logic             nd_rb,
  output logic             bm_we,
  output logic [BLK_W-1:0] bm_addr,
  output logic             bm_bad,
  output logic [CNT_W-1:0] good_count,
  output logic             low_cap
);
  localparam int WBW = $clog2(WB_CYC + 1);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  scan_st_t         st;
  logic [BLK_W-1:0] blk;
  logic             pg;
  logic             bad_acc;
  logic [WBW-1:0]   wb_cnt;

  logic             bus_req;
  bus_kind_t        bus_kind;
  logic [7:0]       bus_byte;
  logic             bus_ack;
  logic [7:0]       bus_rbyte;
  logic [13:0]      row;

  // Named events for the checker
  logic ev_launch;
  logic ev_page_read;
  logic ev_blk_commit;
  logic rb_ready;

  assign row           = row_of(14'(blk), pg);
  assign ev_launch     = start && ((st == S_IDLE) || (st == S_DONE));
  assign ev_page_read  = (st == S_READ) && bus_ack;
  assign ev_blk_commit = (st == S_WRITE);

  bbs_sync #(.STAGES(2)) u_rb_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (nd_rb),
    .q    (rb_ready)
  );

  always_comb begin
    bus_req  = 1'b0;
    bus_kind = BUS_CMD;
    bus_byte = 8'h00;
    case (st)
      S_CMD:  begin bus_req = 1'b1; bus_kind = BUS_CMD;  bus_byte = CMD_SPARE_PTR; end
      S_A0:   begin bus_req = 1'b1; bus_kind = BUS_ADDR; bus_byte = addr_byte(2'd0, row); end
      S_A1:   begin bus_req = 1'b1; bus_kind = BUS_ADDR; bus_byte = addr_byte(2'd1, row); end
      S_A2:   begin bus_req = 1'b1; bus_kind = BUS_ADDR; bus_byte = addr_byte(2'd2, row); end
      S_READ: begin bus_req = 1'b1; bus_kind = BUS_READ; end
      default: ;
    endcase
  end

  bbs_bus_cycler #(.PULSE_CYC(PULSE_CYC)) u_cycler (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (bus_req),
    .kind  (bus_kind),
    .wbyte (bus_byte),
    .ack   (bus_ack),
    .rbyte (bus_rbyte),
    .cle   (nd_cle),
    .ale   (nd_ale),
    .we_n  (nd_we_n),
    .re_n  (nd_re_n),
    .io_out(nd_io_out),
    .io_oe (nd_io_oe),
    .io_in (nd_io_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      blk     <= '0;
      pg      <= 1'b0;
      bad_acc <= 1'b0;
      wb_cnt  <= '0;
      nd_ce_n <= 1'b1;
    end else begin
      if (ev_launch) begin
        st      <= S_CMD;
        blk     <= '0;
        pg      <= 1'b0;
        bad_acc <= 1'b0;
        nd_ce_n <= 1'b0;
      end else begin
        case (st)
          S_CMD: if (bus_ack) st <= S_A0;
          S_A0:  if (bus_ack) st <= S_A1;
          S_A1:  if (bus_ack) st <= S_A2;
          S_A2:  if (bus_ack) begin
            wb_cnt <= '0;
            st     <= S_WB;
          end
          S_WB: begin
            if (wb_cnt == WBW'(WB_CYC - 1)) st <= S_RB;
            else                           wb_cnt <= wb_cnt + 1'b1;
          end
          S_RB: if (rb_ready) st <= S_READ;
          S_READ: if (bus_ack) begin
            bad_acc <= bad_acc | is_marked(bus_rbyte);
            if (!pg) begin
              pg <= 1'b1;
              st <= S_CMD;
            end else begin
              st <= S_WRITE;
            end
          end
          S_WRITE: begin
            bad_acc <= 1'b0;
            pg      <= 1'b0;
            if (blk == LAST_BLK) begin
              st      <= S_DONE;
              nd_ce_n <= 1'b1;
            end else begin
              blk <= blk + 1'b1;
              st  <= S_CMD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign bm_we   = ev_blk_commit;
  assign bm_addr = blk;
  assign bm_bad  = bad_acc;
  assign done    = (st == S_DONE);

  bbs_tally #(.CNT_W(CNT_W), .MIN_GOOD(MIN_GOOD)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_launch),
    .inc   (ev_blk_commit && !bad_acc),
    .closed(done),
    .count (good_count),
    .low   (low_cap)
  );
endmodule

// File: rtl/bbt_scanner_chk.sv
module bbt_scanner_chk #(
  parameter int BLK_W    = 10,
  parameter int CNT_W    = 11,
  parameter int MIN_GOOD = 1014
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic             nd_ce_n,
  input logic             nd_cle,
  input logic             nd_ale,
  input logic             nd_we_n,
  input logic             nd_re_n,
  input logic [7:0]       nd_io_out,
  input logic             bm_we,
  input logic [BLK_W-1:0] bm_addr,
  input logic [CNT_W-1:0] good_count,
  input logic             low_cap,
  input logic             ev_launch,
  input logic             rb_ready
);
  logic [BLK_W:0] exp_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         exp_blk <= '0;
    else if (ev_launch) exp_blk <= '0;
    else if (bm_we)     exp_blk <= exp_blk + 1'b1;
  end

  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nd_cle && nd_ale)); // R10

  AST_CE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nd_we_n || !nd_re_n) |-> !nd_ce_n); // R10

  AST_ONLY_SPARE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (!nd_we_n && nd_cle) |-> (nd_io_out == 8'h50)); // R8

  AST_READ_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nd_re_n) |-> rb_ready); // R3

  AST_BITMAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    bm_we |-> (bm_addr == exp_blk[BLK_W-1:0])); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R9

  AST_LOW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (low_cap == (good_count < CNT_W'(MIN_GOOD)))); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_launch |=> (good_count == $past(good_count)) ||
                   (good_count == $past(good_count) + 1'b1)); // R6

  AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |=> (good_count == '0)); // R6
endmodule

bind bbt_scanner bbt_scanner_chk #(
  .BLK_W(BLK_W), .CNT_W(CNT_W), .MIN_GOOD(MIN_GOOD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .nd_ce_n(nd_ce_n), .nd_cle(nd_cle), .nd_ale(nd_ale),
  .nd_we_n(nd_we_n), .nd_re_n(nd_re_n), .nd_io_out(nd_io_out),
  .bm_we(bm_we), .bm_addr(bm_addr), .good_count(good_count),
  .low_cap(low_cap), .ev_launch(ev_launch), .rb_ready(rb_ready)
);

// File: tb/bbt_scanner_tb.sv
`timescale 1ns/1ps
module bbt_scanner_tb;
  localparam int NB    = 64;
  localparam int MG    = 60;
  localparam int BW    = $clog2(NB);
  localparam int CW    = $clog2(NB + 1);
  localparam int BUSY  = 20;
  localparam int NVEC  = 5;

  // {page0 modulus, page0 residue, page1 modulus, page1 residue, mark byte, expected good}
  localparam logic [47:0] VEC [0:NVEC-1] = '{
    48'h00_00_00_00_00_40,
    48'h10_03_00_00_00_3C,
    48'h00_00_08_00_FE_38,
    48'h20_1F_20_1F_7F_3E,
    48'h15_00_0A_05_01_36
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, nd_ce_n, nd_cle, nd_ale, nd_we_n, nd_re_n, nd_io_oe;
  logic [7:0] nd_io_out;
  logic [7:0] nd_io_in = 8'hFF;
  logic nd_rb = 1'b1;
  logic bm_we, bm_bad, low_cap;
  logic [BW-1:0] bm_addr;
  logic [CW-1:0] good_count;

  always #10 clk = ~clk;

  bbt_scanner #(.NUM_BLOCKS(NB), .MIN_GOOD(MG), .PULSE_CYC(3), .WB_CYC(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .nd_ce_n(nd_ce_n), .nd_cle(nd_cle), .nd_ale(nd_ale),
    .nd_we_n(nd_we_n), .nd_re_n(nd_re_n), .nd_io_out(nd_io_out),
    .nd_io_oe(nd_io_oe), .nd_io_in(nd_io_in), .nd_rb(nd_rb),
    .bm_we(bm_we), .bm_addr(bm_addr), .bm_bad(bm_bad),
    .good_count(good_count), .low_cap(low_cap)
  );

  int checks = 0;
  int fails  = 0;
  int vi     = 0;
  logic mdl_clr = 1'b0;

  function automatic logic page_bad(input int v, input int b, input int p);
    int m, r;
    m = (p == 0) ? int'(VEC[v][47:40]) : int'(VEC[v][31:24]);
    r = (p == 0) ? int'(VEC[v][39:32]) : int'(VEC[v][23:16]);
    return (m != 0) && ((b % m) == r);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Flash model and protocol monitors
  int   seq, reads, writes, addr_idx;
  int   addr_err, busy_err, cmd_err, bus_err, bm_err;
  int   busy_cnt;
  logic [7:0] abyte [0:2];
  logic prev_we = 1'b1, prev_re = 1'b1;

  always @(posedge clk) begin
    prev_we <= nd_we_n;
    prev_re <= nd_re_n;
    if (mdl_clr) begin
      seq <= 0; reads <= 0; writes <= 0; addr_idx <= 0;
      addr_err <= 0; busy_err <= 0; cmd_err <= 0; bus_err <= 0; bm_err <= 0;
      busy_cnt <= 0; nd_rb <= 1'b1;
    end else begin
      if (busy_cnt != 0) begin
        busy_cnt <= busy_cnt - 1;
        if (busy_cnt == 1) nd_rb <= 1'b1;
      end
      if (nd_cle && nd_ale) bus_err <= bus_err + 1;
      if ((!nd_we_n || !nd_re_n) && nd_ce_n) bus_err <= bus_err + 1;
      if (!prev_we && nd_we_n) begin
        if (nd_cle) begin
          if (nd_io_out != 8'h50) cmd_err <= cmd_err + 1;
          addr_idx <= 0;
        end else if (nd_ale) begin
          abyte[addr_idx] = nd_io_out;
          if (addr_idx == 2) begin
            if (abyte[0] != 8'h05 ||
                {abyte[2], abyte[1]} != 16'((seq / 2) * 16 + (seq % 2)))
              addr_err <= addr_err + 1;
            nd_rb    <= 1'b0;
            busy_cnt <= BUSY;
          end
          addr_idx <= addr_idx + 1;
        end
      end
      if (prev_re && !nd_re_n) begin
        if (!nd_rb) busy_err <= busy_err + 1;
        nd_io_in <= page_bad(vi, seq / 2, seq % 2) ? VEC[vi][15:8] : 8'hFF;
        reads <= reads + 1;
        seq   <= seq + 1;
      end
      if (bm_we) begin
        if (int'(bm_addr) != writes ||
            bm_bad != (page_bad(vi, writes, 0) || page_bad(vi, writes, 1)))
          bm_err <= bm_err + 1;
        writes <= writes + 1;
      end
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic clear_model();
    @(negedge clk) mdl_clr = 1'b1;
    @(negedge clk) mdl_clr = 1'b0;
  endtask

  task automatic launch_and_wait();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic check_reset_state();
    check("R1 ce_n", nd_ce_n, 1);
    check("R1 we_n", nd_we_n, 1);
    check("R1 re_n", nd_re_n, 1);
    check("R1 cle/ale", {nd_cle, nd_ale}, 0);
    check("R1 io_oe", nd_io_oe, 0);
    check("R1 done", done, 0);
    check("R1 bm_we", bm_we, 0);
    check("R1 good_count", good_count, 0);
    check("R1 low_cap", low_cap, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    for (int i = 0; i < NVEC; i++) begin
      int eg;
      vi = i;
      eg = int'(VEC[i][7:0]);
      clear_model();
      launch_and_wait();
      check("R6 good_count", good_count, eg);
      check("R7 low_cap", low_cap, (eg < MG) ? 1 : 0);
      check("R5 bitmap writes", writes, NB);
      check("R5 bitmap content", bm_err, 0);
      check("R4 page reads", reads, 2 * NB);
      check("R2 address bytes", addr_err, 0);
      check("R3 read while busy", busy_err, 0);
      check("R8 command bytes", cmd_err, 0);
      check("R10 bus strobes", bus_err, 0);
    end

    // R9: done holds without start, result stable
    repeat (40) @(negedge clk);
    check("R9 done held", done, 1);
    check("R9 count held", good_count, int'(VEC[NVEC-1][7:0]));

    // R9/R6: restart from done clears count, then runs a fresh scan
    vi = 0;
    clear_model();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R9 done drops on restart", done, 0);
    check("R6 count cleared on start", good_count, 0);
    while (!done) @(negedge clk);
    check("R6 rerun all good", good_count, NB);
    check("R7 at full count", low_cap, 0);

    // R1: reset in the middle of a scan
    vi = 4;
    clear_model();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (700) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule